// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block turns a handful of register writes into one complete serial-flash command on a single-lane SPI bus (mode 0). Software loads an opcode and an address, stages outgoing data in a small word buffer if the command writes, and then writes a configuration word with its start bit set. The block lowers the chip select, clocks out the opcode, an optional address, an optional run of dummy bytes and an optional data phase, then raises chip select and clears the start bit.

In a read data phase the bytes arriving on the input line are packed into the same buffer. They can be read once the start bit has cleared. Byte n of the data phase maps to buffer word n/4, bit lane (n mod 4)*8, so the first byte on the wire is the low byte of word 0. The buffer depth is a build parameter. A read-only version word tells software which depth was built.

The register port is a plain 32-bit port with no back-pressure. A write is taken in the cycle `reg_we` is high, and read data is a combinational function of `reg_addr`. Completion is found by polling bit 0 of the configuration word.

Top module: `spi_flash_cmd_seq`

## Requirements
- R1: Register offsets are: configuration 0x300, opcode 0x308, address 0x30C, buffer word k at 0x400+4k, version 0x1F8. After reset every writable register and every buffer word reads 0, all chip-select outputs are high, and the serial clock and output line are low.
- R2: A write to 0x300 with bit 0 set while idle launches a command. Bit 0 then reads 1 from the next cycle until the command ends, and it reads 0 afterwards.
- R3: The configuration fields are:
  - bit 0: start/busy.
  - bits 2:1: chip select number.
  - bit 3: address phase enable.
  - bits 6:4: dummy byte count.
  - bit 7: data phase enable.
  - bit 8: direction, 1 for read and 0 for write.
  - bits 9 upward: data byte count minus one, log2(4*BUF_WORDS) bits wide.

  All fields except bit 0 read back as written.
- R4: The frame carries, in this order: the opcode; then, if enabled, ADDR_BYTES address bytes (default 3) taken from the low bits of the address register, most significant first; then the dummy bytes, each 0x00; then the data phase. Each byte goes out most significant bit first. During a read data phase the output line sends 0x00.
- R5: A write data phase sends byte n from buffer word n/4, lane (n mod 4)*8. The bytes received during the command are ignored, and the buffer is left unchanged.
- R6: A read data phase stores received byte n into word n/4, lane (n mod 4)*8. Bytes beyond the count keep their old value.
- R7: The serial clock idles low and has a period of exactly CLK_DIV system clocks. The output line changes only while the serial clock is low, and input is sampled on the rising edge.
- R8: Only the selected chip-select output goes low. There are at least CLK_DIV system clocks from its fall to the first rising edge, and at least CLK_DIV from the last falling edge to its rise. The serial clock stays low while chip select is high.
- R9: While bit 0 reads 1, writes to the configuration, opcode, address and buffer registers are ignored.
- R10: The version word reads 0x351 for a 64-word buffer and 0x350 otherwise, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The in-design assertions assume software writes the configuration word only with a chip number below NUM_CS and with a data count that fits the buffer. The bench keeps the chip field at zero, and the count field's width bounds the length. The assertions also take for granted that the flash input never changes in the same cycle the sequencer samples it. The bench's flash model updates its output only on observed falling clock edges, so the value is settled well before the next rise. Random commands mix every phase combination, and writes are attempted only while a long command is still running.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;

  localparam logic [11:0] OFS_VERSION = 12'h1F8;
  localparam logic [11:0] OFS_CFG     = 12'h300;
  localparam logic [11:0] OFS_OPC     = 12'h308;
  localparam logic [11:0] OFS_ADDR    = 12'h30C;
  localparam logic [11:0] OFS_BUF     = 12'h400;

  localparam int CFG_LEN_LSB = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_HOLD
  } seq_state_e;

endpackage

// File: rtl/spi_seq_buf.sv
`timescale 1ns/1ps
// Byte-organised staging buffer: word port for the register side,
// byte port for the serial engine.
module spi_seq_buf #(
  parameter int WORDS = 16,
  localparam int IDX_W = $clog2(WORDS),
  localparam int BIDX_W = $clog2(WORDS * 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              eng_we,
  input  logic [BIDX_W-1:0] eng_widx,
  input  logic [7:0]        eng_wbyte,
  input  logic [BIDX_W-1:0] eng_ridx,
  output logic [7:0]        eng_rbyte
);

  localparam int NBYTES = WORDS * 4;

  logic [7:0] bytes_q [NBYTES];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_lane
      localparam int BI = w * 4 + b;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bytes_q[BI] <= '0;
        end else if (host_we && host_idx == IDX_W'(w)) begin
          bytes_q[BI] <= host_wdata[8*b +: 8];
        end else if (eng_we && eng_widx == BIDX_W'(BI)) begin
          bytes_q[BI] <= eng_wbyte;
        end
      end
    end
  end

  assign host_rdata = {bytes_q[{host_idx, 2'd3}], bytes_q[{host_idx, 2'd2}],
                       bytes_q[{host_idx, 2'd1}], bytes_q[{host_idx, 2'd0}]};
  assign eng_rbyte  = bytes_q[eng_ridx];

  // Host writes are blocked while a command runs; capture only happens then.
  assert_no_collision_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> !host_we);

endmodule

// File: rtl/spi_seq_regs.sv
`timescale 1ns/1ps
// Register decode: command fields, opcode, address, version and buffer window.
module spi_seq_regs
  import spi_seq_pkg::*;
#(
  parameter int          WORDS   = 16,
  parameter int          LEN_W   = 6,
  parameter logic [31:0] VERSION = 32'h350,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             busy,
  output logic             start,
  output logic [1:0]       cs_sel,
  output logic             addr_en,
  output logic [2:0]       dummy_cnt,
  output logic             data_en,
  output logic             rd_mode,
  output logic [LEN_W-1:0] len_m1,
  output logic [7:0]       opcode,
  output logic [31:0]      addr_val,
  output logic             host_we,
  output logic [IDX_W-1:0] host_idx,
  output logic [31:0]      host_wdata,
  input  logic [31:0]      host_rdata
);

  logic        sel_cfg, sel_opc, sel_addr, sel_ver, sel_buf, accept;
  logic [11:0] buf_off;
  logic [31:0] cfg_word;

  assign buf_off  = bus_addr - OFS_BUF;
  assign sel_cfg  = (bus_addr == OFS_CFG);
  assign sel_opc  = (bus_addr == OFS_OPC);
  assign sel_addr = (bus_addr == OFS_ADDR);
  assign sel_ver  = (bus_addr == OFS_VERSION);
  assign sel_buf  = (bus_addr >= OFS_BUF) && (buf_off < 12'(WORDS * 4));
  assign accept   = bus_we && !busy;

  assign start      = accept && sel_cfg && bus_wdata[0];
  assign host_we    = accept && sel_buf;
  assign host_idx   = buf_off[IDX_W+1:2];
  assign host_wdata = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sel    <= '0;
      addr_en   <= 1'b0;
      dummy_cnt <= '0;
      data_en   <= 1'b0;
      rd_mode   <= 1'b0;
      len_m1    <= '0;
      opcode    <= '0;
      addr_val  <= '0;
    end else if (accept) begin
      if (sel_cfg) begin
        cs_sel    <= bus_wdata[2:1];
        addr_en   <= bus_wdata[3];
        dummy_cnt <= bus_wdata[6:4];
        data_en   <= bus_wdata[7];
        rd_mode   <= bus_wdata[8];
        len_m1    <= bus_wdata[CFG_LEN_LSB +: LEN_W];
      end
      if (sel_opc)  opcode   <= bus_wdata[7:0];
      if (sel_addr) addr_val <= bus_wdata;
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[0] = busy;
    cfg_word[2:1] = cs_sel;
    cfg_word[3] = addr_en;
    cfg_word[6:4] = dummy_cnt;
    cfg_word[7] = data_en;
    cfg_word[8] = rd_mode;
    cfg_word[CFG_LEN_LSB +: LEN_W] = len_m1;
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_cfg)       bus_rdata = cfg_word;
    else if (sel_opc)  bus_rdata = {24'd0, opcode};
    else if (sel_addr) bus_rdata = addr_val;
    else if (sel_ver)  bus_rdata = VERSION;
    else if (sel_buf)  bus_rdata = host_rdata;
  end

  assert_locked_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && sel_opc) |=> $stable(opcode));
  assert_locked_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && sel_cfg) |=> $stable(len_m1) && $stable(rd_mode));
  assert_locked_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we && sel_addr) |=> $stable(addr_val));

endmodule

// File: rtl/spi_seq_engine.sv
`timescale 1ns/1ps
// Serial engine: sequences the phases of one command in SPI mode 0.
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int ADDR_BYTES = 3,
  parameter int NUM_CS     = 1,
  parameter int LEN_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cs_sel,
  input  logic              addr_en,
  input  logic [2:0]        dummy_cnt,
  input  logic              data_en,
  input  logic              rd_mode,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [7:0]        opcode,
  input  logic [31:0]       addr_val,
  input  logic [7:0]        buf_rbyte,
  output logic [LEN_W-1:0]  buf_ridx,
  output logic [LEN_W-1:0]  buf_widx,
  output logic              buf_we,
  output logic [7:0]        buf_wbyte,
  output logic              busy,
  output logic              spi_sclk,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int HALF = CLK_DIV / 2;
  localparam int TC_W = (HALF > 1) ? $clog2(HALF) : 1;

  seq_state_e       state_q, nxt_state;
  logic [TC_W-1:0]  tcnt_q;
  logic             tick, sclk_q, wait_q, last_byte;
  logic [2:0]       bit_q;
  logic [LEN_W-1:0] cnt_q, nxt_cnt;
  logic [7:0]       tx_q, ld_byte;
  logic [6:0]       rx_q;
  logic [4:0]       sh_amt;

  function automatic seq_state_e after_phase(seq_state_e cur, logic aen,
                                             logic [2:0] dcnt, logic den);
    seq_state_e n;
    n = ST_HOLD;
    if (cur == ST_OPC && aen)                              n = ST_ADDR;
    else if ((cur == ST_OPC || cur == ST_ADDR) && dcnt != 3'd0) n = ST_DUMMY;
    else if (cur != ST_DATA && den)                        n = ST_DATA;
    return n;
  endfunction

  assign tick = (tcnt_q == TC_W'(HALF - 1));

  always_comb begin
    case (state_q)
      ST_OPC:   last_byte = 1'b1;
      ST_ADDR:  last_byte = (cnt_q == LEN_W'(ADDR_BYTES - 1));
      ST_DUMMY: last_byte = ((cnt_q + LEN_W'(1)) == LEN_W'(dummy_cnt));
      ST_DATA:  last_byte = (cnt_q == len_m1);
      default:  last_byte = 1'b0;
    endcase
    nxt_state = last_byte ? after_phase(state_q, addr_en, dummy_cnt, data_en) : state_q;
    nxt_cnt   = last_byte ? '0 : cnt_q + LEN_W'(1);
  end

  assign sh_amt   = 5'((ADDR_BYTES - 1 - int'(nxt_cnt)) * 8);
  assign buf_ridx = nxt_cnt;

  always_comb begin
    case (nxt_state)
      ST_OPC:  ld_byte = opcode;
      ST_ADDR: ld_byte = 8'(addr_val >> sh_amt);
      ST_DATA: ld_byte = rd_mode ? 8'h00 : buf_rbyte;
      default: ld_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      sclk_q  <= 1'b0;
      wait_q  <= 1'b0;
      bit_q   <= '0;
      cnt_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
    end else if (state_q == ST_IDLE) begin
      if (start) begin
        state_q <= ST_SETUP;
        tcnt_q  <= '0;
        sclk_q  <= 1'b0;
        wait_q  <= 1'b0;
        bit_q   <= '0;
        cnt_q   <= '0;
        tx_q    <= opcode;
      end
    end else begin
      tcnt_q <= tick ? '0 : tcnt_q + TC_W'(1);
      if (tick) begin
        case (state_q)
          ST_SETUP, ST_HOLD: begin
            wait_q <= !wait_q;
            if (wait_q) state_q <= (state_q == ST_SETUP) ? ST_OPC : ST_IDLE;
          end
          default: begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rx_q   <= {rx_q[5:0], spi_miso};
            end else begin
              sclk_q <= 1'b0;
              if (bit_q == 3'd7) begin
                bit_q   <= '0;
                state_q <= nxt_state;
                cnt_q   <= nxt_cnt;
                tx_q    <= ld_byte;
              end else begin
                bit_q <= bit_q + 3'd1;
                tx_q  <= {tx_q[6:0], 1'b0};
              end
            end
          end
        endcase
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign spi_sclk  = sclk_q;
  assign spi_mosi  = busy ? tx_q[7] : 1'b0;
  assign buf_we    = (state_q == ST_DATA) && rd_mode && tick && !sclk_q && (bit_q == 3'd7);
  assign buf_wbyte = {rx_q, spi_miso};
  assign buf_widx  = cnt_q;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spi_cs_n[i] = !(busy && (cs_sel == 2'(i)));
  end

  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&spi_cs_n) |-> !spi_sclk);
  assert_single_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));
  assert_mosi_low_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));
  assert_done_after_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(state_q) == ST_HOLD) && !spi_sclk);
  assert_setup_clock_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP) |-> !spi_sclk);

endmodule

// File: rtl/spi_flash_cmd_seq.sv
`timescale 1ns/1ps
// Top: register-launched serial-flash command sequencer.
module spi_flash_cmd_seq #(
  parameter int BUF_WORDS  = 16,
  parameter int ADDR_BYTES = 3,
  parameter int CLK_DIV    = 4,
  parameter int NUM_CS     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sclk,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int          LEN_W   = $clog2(BUF_WORDS * 4);
  localparam int          IDX_W   = $clog2(BUF_WORDS);
  localparam logic [31:0] VERSION = (BUF_WORDS == 64) ? 32'h351 : 32'h350;

  logic             busy, start, addr_en, data_en, rd_mode;
  logic [1:0]       cs_sel;
  logic [2:0]       dummy_cnt;
  logic [LEN_W-1:0] len_m1, eng_ridx, eng_widx;
  logic [7:0]       opcode, eng_rbyte, eng_wbyte;
  logic [31:0]      addr_val, host_wdata, host_rdata;
  logic             host_we, eng_we;
  logic [IDX_W-1:0] host_idx;

  spi_seq_regs #(
    .WORDS(BUF_WORDS), .LEN_W(LEN_W), .VERSION(VERSION)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_we(reg_we), .bus_addr(reg_addr), .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
    .busy(busy), .start(start), .cs_sel(cs_sel), .addr_en(addr_en),
    .dummy_cnt(dummy_cnt), .data_en(data_en), .rd_mode(rd_mode), .len_m1(len_m1),
    .opcode(opcode), .addr_val(addr_val),
    .host_we(host_we), .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  spi_seq_buf #(.WORDS(BUF_WORDS)) buf_i (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_we(eng_we), .eng_widx(eng_widx), .eng_wbyte(eng_wbyte),
    .eng_ridx(eng_ridx), .eng_rbyte(eng_rbyte)
  );

  spi_seq_engine #(
    .CLK_DIV(CLK_DIV), .ADDR_BYTES(ADDR_BYTES), .NUM_CS(NUM_CS), .LEN_W(LEN_W)
  ) engine_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cs_sel(cs_sel), .addr_en(addr_en), .dummy_cnt(dummy_cnt), .data_en(data_en),
    .rd_mode(rd_mode), .len_m1(len_m1), .opcode(opcode), .addr_val(addr_val),
    .buf_rbyte(eng_rbyte), .buf_ridx(eng_ridx), .buf_widx(eng_widx),
    .buf_we(eng_we), .buf_wbyte(eng_wbyte), .busy(busy),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

endmodule

// File: tb/spi_flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module spi_flash_cmd_seq_tb_top;

  localparam int DIV = 4;
  localparam int AB  = 3;
  localparam int NB  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_mosi;
  logic [0:0]  spi_cs_n;
  logic        spi_miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_flash_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0, fails = 0;
  logic [7:0] salt_g = 8'h00;
  logic [7:0] shadow [NB];

  function automatic logic [7:0] resp_byte(int k, logic [7:0] s);
    return 8'(k * 29 + int'(s)) ^ 8'h5A;
  endfunction

  // Flash model and pin monitor, all sampled on the falling system clock edge.
  logic [7:0] frame_b [128];
  int frame_n = 0, bitpos = 0, cyc = 0;
  int t_csf = 0, t_r = 0, t_f = 0, setup_gap = 0, hold_gap = 0;
  int period_bad = 0, idle_bad = 0, mosi_bad = 0;
  logic first_rise = 1'b0, prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;
  logic [7:0] sh_in = '0;

  always @(negedge clk) begin
    logic [7:0] rb;
    cyc++;
    if (prev_cs && !spi_cs_n[0]) begin
      bitpos = 0; frame_n = 0; t_csf = cyc; first_rise = 1'b1;
      rb = resp_byte(0, salt_g); spi_miso = rb[7];
    end
    if (!spi_cs_n[0]) begin
      if (!prev_sclk && spi_sclk) begin
        if (first_rise) setup_gap = cyc - t_csf;
        else if (cyc - t_r != DIV) period_bad++;
        first_rise = 1'b0; t_r = cyc;
        sh_in = {sh_in[6:0], spi_mosi};
        bitpos++;
        if (bitpos % 8 == 0) begin
          if (frame_n < 128) frame_b[frame_n] = sh_in;
          frame_n++;
        end
      end
      if (prev_sclk && !spi_sclk) begin
        t_f = cyc;
        rb = resp_byte(bitpos / 8, salt_g);
        spi_miso = rb[3'(7 - bitpos % 8)];
      end
      if (prev_sclk && spi_sclk && spi_mosi != prev_mosi) mosi_bad++;
    end
    if (!prev_cs && spi_cs_n[0]) hold_gap = cyc - t_f;
    if (spi_cs_n[0] && spi_sclk) idle_bad++;
    prev_cs = spi_cs_n[0]; prev_sclk = spi_sclk; prev_mosi = spi_mosi;
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic run_cmd(input logic [7:0] opc, input logic [31:0] adr, input bit aen,
                         input logic [2:0] dum, input bit den, input bit rdm,
                         input int len, input bit poke);
    logic [31:0] v, cfg;
    logic [7:0]  exp_b [128];
    int exp_n, hdr, mism, poll;
    string dreq;
    if (den && !rdm) begin
      for (int w = 0; w < (len + 3) / 4; w++) begin
        v = $urandom;
        wr(12'h400 + 12'(4 * w), v);
        for (int b = 0; b < 4; b++) shadow[4 * w + b] = v[8 * b +: 8];
      end
    end
    salt_g = 8'($urandom);
    wr(12'h30C, adr);
    wr(12'h308, {24'd0, opc});
    cfg = (32'(len - 1) << 9) | (32'(rdm) << 8) | (32'(den) << 7) |
          (32'(dum) << 4) | (32'(aen) << 3) | 32'h1;
    wr(12'h300, cfg);
    rd(12'h300, v);
    check(v[0] == 1'b1, "R2", "start bit while running", {31'd0, v[0]}, 32'h1);
    if (poke) begin
      // R9: these writes land while the command is running
      wr(12'h308, {24'd0, ~opc});
      wr(12'h30C, ~adr);
      wr(12'h300, cfg ^ 32'h0000_01F8);
      wr(12'h400, 32'hDEAD_BEEF);
    end
    poll = 0;
    do begin rd(12'h300, v); poll++; end while (v[0] && poll < 20000);
    check(v[0] == 1'b0, "R2", "start bit cleared at end", {31'd0, v[0]}, 32'h0);
    check(v == (cfg & ~32'h1), poke ? "R9" : "R3", "config readback", v, cfg & ~32'h1);
    repeat (3) @(negedge clk);
    exp_n = 0;
    exp_b[exp_n++] = opc;
    if (aen) for (int k = 0; k < AB; k++) exp_b[exp_n++] = adr[8 * (AB - 1 - k) +: 8];
    for (int k = 0; k < int'(dum); k++) exp_b[exp_n++] = 8'h00;
    hdr = exp_n;
    if (den) for (int k = 0; k < len; k++) exp_b[exp_n++] = rdm ? 8'h00 : shadow[k];
    check(frame_n == exp_n, "R4", "frame byte count", 32'(frame_n), 32'(exp_n));
    mism = -1;
    for (int k = 0; k < exp_n && k < frame_n; k++)
      if (mism < 0 && frame_b[k] != exp_b[k]) mism = k;
    if (mism >= 0)
      check(1'b0, (den && !rdm && mism >= hdr) ? "R5" : (poke ? "R9" : "R4"),
            "frame byte", {24'd0, frame_b[mism]}, {24'd0, exp_b[mism]});
    else
      check(1'b1, "R4", "frame bytes", 0, 0);
    if (den && rdm) for (int k = 0; k < len; k++) shadow[k] = resp_byte(hdr + k, salt_g);
    dreq = (den && rdm) ? "R6" : (poke ? "R9" : "R5");
    mism = -1;
    for (int w = 0; w < NB / 4; w++) begin
      rd(12'h400 + 12'(4 * w), v);
      if (mism < 0 && v != {shadow[4*w+3], shadow[4*w+2], shadow[4*w+1], shadow[4*w]}) begin
        mism = w;
        check(1'b0, dreq, "buffer word", v,
              {shadow[4*w+3], shadow[4*w+2], shadow[4*w+1], shadow[4*w]});
      end
    end
    if (mism < 0) check(1'b1, dreq, "buffer contents", 0, 0);
    check(setup_gap >= DIV, "R8", "cs setup clocks", 32'(setup_gap), DIV);
    check(hold_gap >= DIV, "R8", "cs hold clocks", 32'(hold_gap), DIV);
    check(period_bad == 0, "R7", "sclk period errors", 32'(period_bad), 0);
    check(mosi_bad == 0, "R7", "mosi moved while sclk high", 32'(mosi_bad), 0);
    check(idle_bad == 0, "R8", "sclk high with cs high", 32'(idle_bad), 0);
  endtask

  task automatic main_seq();
    logic [31:0] v;
    repeat (4) @(negedge clk);
    check(spi_cs_n[0] == 1'b1 && spi_sclk == 1'b0 && spi_mosi == 1'b0, "R1",
          "pins in reset", {29'd0, spi_cs_n[0], spi_sclk, spi_mosi}, 32'h4);
    rst_n = 1'b1;
    rd(12'h300, v); check(v == 0, "R1", "config after reset", v, 0);
    rd(12'h308, v); check(v == 0, "R1", "opcode after reset", v, 0);
    rd(12'h30C, v); check(v == 0, "R1", "address after reset", v, 0);
    rd(12'h43C, v); check(v == 0, "R1", "last buffer word after reset", v, 0);
    for (int i = 0; i < NB; i++) shadow[i] = 8'h00;
    rd(12'h1F8, v); check(v == 32'h350, "R10", "version", v, 32'h350);
    wr(12'h1F8, 32'hFFFF_FFFF);
    rd(12'h1F8, v); check(v == 32'h350, "R10", "version after write", v, 32'h350);
    // directed corners
    run_cmd(8'h06, 32'h0, 1'b0, 3'd0, 1'b0, 1'b0, 1, 1'b0);            // opcode only
    run_cmd(8'h0B, 32'hFF12_3456, 1'b1, 3'd7, 1'b0, 1'b0, 1, 1'b0);    // max dummy, no data
    run_cmd(8'h03, 32'h00AB_CDEF, 1'b1, 3'd0, 1'b1, 1'b1, 64, 1'b1);   // full read, pokes
    run_cmd(8'h02, 32'h0012_0000, 1'b1, 3'd0, 1'b1, 1'b0, 1, 1'b0);    // one-byte write
    run_cmd(8'h02, 32'h0077_0001, 1'b1, 3'd1, 1'b1, 1'b0, 5, 1'b0);    // partial word write
    run_cmd(8'h9F, 32'h0, 1'b0, 3'd0, 1'b1, 1'b1, 3, 1'b0);            // short read keeps tail
    run_cmd(8'h02, 32'h0001_0203, 1'b1, 3'd2, 1'b1, 1'b0, 40, 1'b1);   // write, pokes
    for (int n = 0; n < 24; n++)
      run_cmd(8'($urandom), $urandom, 1'($urandom), 3'($urandom), ($urandom % 4) != 0,
              1'($urandom), 1 + int'($urandom % 64), 1'b0);
  endtask

  initial begin
    bit wd_hit;
    wd_hit = 1'b0;
    void'($urandom(32'h5EED));
    fork
      main_seq();
      begin repeat (190000) @(posedge clk); wd_hit = 1'b1; end
    join_any
    if (wd_hit) check(1'b0, "R2", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule